// File: doc/BRIEF.md
# Sector program and erase sequencer

This block runs the automatic program and erase operations of a small sector store that models a flash array. The host first fills a staging register, one byte per cycle, with the data for one sector. It then issues a single command that names an operation, a sector and, for one of the operations, a start column. The block accepts the command and drops `ready`. It checks the precondition of the operation against the stored bytes, one byte per cycle. If the precondition holds, it writes the range and then makes a verify pass over the same range. It keeps `ready` low for a fixed number of cycles, `BUSY_CYCLES`, whatever the operation or its range. When `ready` rises, the status word reports completion, a precondition failure and a verify error.

A program operation can only clear bits. Each stored byte becomes its old value AND the staging byte. Erase returns every byte of a sector to 0xFF. The program variants differ in two ways: the column range they cover, and whether each target byte must read 0xFF before anything is written. A sector holds `DATA_BYTES + SPARE_BYTES` bytes. The full-size geometry is 2048 + 64. The spare area starts at column `DATA_BYTES`. A byte-wide read port lets the host inspect any stored byte at any time.

Top module: `sps_sequencer`

## Requirements
- R1: After reset, `ready` is 1, `status` is 0, and every byte of every sector reads 0xFF on `rd_data`.
- R2: A command with `cmd_valid`=1 and `cmd_op` in 0..4 is accepted in any cycle where `ready`=1. Accepting it makes `ready` 0 from the next cycle for exactly `BUSY_CYCLES` cycles. When `ready` returns to 1, `status[0]` (done) is 1. While `ready`=0, `status` is 0.
- R3: Opcode 0 (erase) sets all bytes of the addressed sector to 0xFF and leaves the other sectors unchanged.
- R4: Opcode 1 (plain program) writes columns 0 to N-1 with no precondition. Each byte becomes old AND staging byte, so a 1 in the staging data leaves the stored bit as it was.
- R5: Opcode 2 (column program) writes columns `cmd_col` to N-1 by the AND rule and leaves the columns below `cmd_col` unchanged. If any target byte is not 0xFF, `status[1]` (fail) is set and the sector is left unchanged.
- R6: Opcode 3 (spare program) writes only columns `DATA_BYTES` to N-1 by the AND rule. It applies the same 0xFF precondition on those columns and sets fail with no change when the precondition does not hold.
- R7: Opcode 4 (blank program) writes columns 0 to N-1 only if the whole sector reads 0xFF. Otherwise it sets fail and leaves the sector unchanged.
- R8: Commands are ignored in three cases: while `ready`=0, when `cmd_op` is 5 to 7, and when a column program has `cmd_col` ≥ N. An ignored command while busy does not restart or lengthen the busy period. An opcode of 5 to 7 leaves `ready` and `status` unchanged. A column program with `cmd_col` ≥ N completes without fail and changes nothing.
- R9: Writes to the staging register while `ready`=0 are ignored. The operation in progress, and any later one, use the staging contents as they stood when the command was accepted.
- R10: `status[2]` (verify error) is set when a byte in the operated range does not read back as expected: 0xFF after an erase, and no 1 where the staging byte holds 0 after a program. It stays 0 for every operation of a correct design.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stg_we | input | 1 | Staging byte write strobe |
| stg_col | input | CW | Staging column to write |
| stg_wdata | input | 8 | Staging byte value |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code (0 erase, 1 plain, 2 column, 3 spare, 4 blank) |
| cmd_sector | input | SW | Target sector |
| cmd_col | input | CW | Start column for opcode 2 |
| rd_sector | input | SW | Host read sector |
| rd_col | input | CW | Host read column |
| rd_data | output | 8 | Stored byte at the host read address (combinational) |
| ready | output | 1 | 1 when idle, 0 while an operation runs |
| status | output | 3 | bit0 done, bit1 precondition fail, bit2 verify error |

## Verification
The bench uses the default parameters: 4 sectors of 32 data bytes plus 4 spare bytes, and `BUSY_CYCLES` = 116. This small geometry lets every sector be read back in full after each command. It also makes it cheap to reach the edge columns: the first spare column, the last column, and a start column just past the end. With the short busy window, several dozen random commands fit in the run, together with directed precondition failures and commands and staging writes injected while busy. The window still leaves room for the worst-case check, write and verify scan.

// File: rtl/sps_pkg.sv
// Package: shared operation codes and engine phases for the sector
// program/erase sequencer. Assumes a 3-bit opcode field.
package sps_pkg;

    typedef enum logic [2:0] {
        OP_ERASE      = 3'd0,
        OP_PROG_AND   = 3'd1,
        OP_PROG_COL   = 3'd2,
        OP_PROG_SPARE = 3'd3,
        OP_PROG_BLANK = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CHECK,
        PH_WRITE,
        PH_VERIFY,
        PH_HOLD
    } phase_e;

    localparam int STAT_DONE = 0;
    localparam int STAT_FAIL = 1;
    localparam int STAT_VERR = 2;
    localparam int STAT_W    = 3;
    localparam logic [2:0] OP_LAST = 3'd4;

endpackage

// File: rtl/sps_byte_store.sv
// Module: byte-wide storage with one synchronous write port and RD_PORTS
// combinational read ports. Resets every byte to 0xFF (erased state).
// Assumes DEPTH is small enough for register storage.
module sps_byte_store #(
    parameter int DEPTH    = 16,
    parameter int RD_PORTS = 1,
    localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [AW-1:0]                 waddr,
    input  logic [7:0]                    wdata,
    input  logic [RD_PORTS-1:0][AW-1:0]   raddr,
    output logic [RD_PORTS-1:0][7:0]      rdata
);

    logic [7:0] mem [DEPTH];

    // Reset to erased contents, otherwise write the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One combinational read path per port.
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end

endmodule

// File: rtl/sps_busy_timer.sv
// Module: fixed-length busy window. A start pulse loads BUSY_CYCLES; ready
// is high only when the count is zero. Assumes start arrives only when ready.
module sps_busy_timer #(
    parameter int BUSY_CYCLES = 16,
    localparam int CNTW       = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);

    logic [CNTW-1:0] cnt_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= CNTW'(BUSY_CYCLES);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign ready = (cnt_q == '0);

endmodule

// File: rtl/sps_engine.sv
// Module: operation engine. On start it latches the command, scans the
// target range once for the blank precondition (when required), once to
// write (AND rule or 0xFF), and once to verify, one byte per cycle. All
// ranges end at the last column of the sector. Assumes the caller keeps
// the staging contents stable while the engine runs.
module sps_engine
    import sps_pkg::*;
#(
    parameter int SECTORS    = 4,
    parameter int N          = 36,
    parameter int SPARE_COL  = 32,
    localparam int CW        = $clog2(N),
    localparam int SW        = (SECTORS > 1) ? $clog2(SECTORS) : 1,
    localparam int AW        = $clog2(SECTORS * N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_in,
    input  logic [SW-1:0] sector_in,
    input  logic [CW-1:0] col_in,
    input  logic [7:0]    arr_rdata,
    input  logic [7:0]    stg_rdata,
    output logic [AW-1:0] arr_addr,
    output logic          arr_we,
    output logic [7:0]    arr_wdata,
    output logic [CW-1:0] stg_addr,
    output logic          fail,
    output logic          verr
);

    localparam logic [CW-1:0] LAST = CW'(N - 1);

    phase_e        phase_q;
    op_e           op_q;
    logic [SW-1:0] sec_q;
    logic [CW-1:0] idx_q;
    logic [CW-1:0] first_q;
    logic          fail_q;
    logic          verr_q;

    logic [CW-1:0] start_col;
    logic          need_check;
    logic          at_last;
    logic [7:0]    expect_ok_mask;
    logic          verify_bad;

    // First column and precondition need, from the incoming opcode.
    always_comb begin
        start_col  = '0;
        need_check = 1'b0;
        case (op_e'(op_in))
            OP_PROG_COL:   begin start_col = col_in;           need_check = 1'b1; end
            OP_PROG_SPARE: begin start_col = CW'(SPARE_COL);   need_check = 1'b1; end
            OP_PROG_BLANK: begin start_col = '0;               need_check = 1'b1; end
            default:       begin start_col = '0;               need_check = 1'b0; end
        endcase
    end

    assign at_last  = (idx_q == LAST);
    assign arr_addr = AW'(sec_q) * AW'(N) + AW'(idx_q);
    assign stg_addr = idx_q;

    // Write path: erase forces all ones, program can only clear bits.
    always_comb begin
        arr_we    = (phase_q == PH_WRITE);
        arr_wdata = (op_q == OP_ERASE) ? 8'hFF : (arr_rdata & stg_rdata);
    end

    // Verify: after erase every bit must be 1; after program no stored 1
    // may remain where the staging byte holds a 0.
    always_comb begin
        expect_ok_mask = (op_q == OP_ERASE) ? 8'hFF : ~stg_rdata;
        if (op_q == OP_ERASE) verify_bad = (arr_rdata != 8'hFF);
        else                  verify_bad = ((arr_rdata & expect_ok_mask) != 8'h00);
    end

    // Phase sequencing and range scanning, one column per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            op_q    <= OP_ERASE;
            sec_q   <= '0;
            idx_q   <= '0;
            first_q <= '0;
            fail_q  <= 1'b0;
            verr_q  <= 1'b0;
        end else if (start) begin
            op_q    <= op_e'(op_in);
            sec_q   <= sector_in;
            idx_q   <= start_col;
            first_q <= start_col;
            fail_q  <= 1'b0;
            verr_q  <= 1'b0;
            if (start_col > LAST) phase_q <= PH_HOLD;
            else if (need_check)  phase_q <= PH_CHECK;
            else                  phase_q <= PH_WRITE;
        end else begin
            case (phase_q)
                PH_CHECK: begin
                    if (arr_rdata != 8'hFF) begin
                        fail_q  <= 1'b1;
                        phase_q <= PH_HOLD;
                    end else if (at_last) begin
                        idx_q   <= first_q;
                        phase_q <= PH_WRITE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                    end
                end
                PH_WRITE: begin
                    if (at_last) begin
                        idx_q   <= first_q;
                        phase_q <= PH_VERIFY;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                    end
                end
                PH_VERIFY: begin
                    if (verify_bad) verr_q <= 1'b1;
                    if (at_last) phase_q <= PH_HOLD;
                    else         idx_q   <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign fail = fail_q;
    assign verr = verr_q;

endmodule

// File: rtl/sps_sequencer.sv
// Module: top of the sector program/erase sequencer. Gates commands and
// staging writes with ready, holds busy for a fixed window, and exposes
// status once the window ends. Assumes BUSY_CYCLES >= 3*N + 2 so the
// engine always finishes inside the window.
module sps_sequencer
    import sps_pkg::*;
#(
    parameter int SECTORS     = 4,
    parameter int DATA_BYTES  = 32,
    parameter int SPARE_BYTES = 4,
    parameter int BUSY_CYCLES = 3 * (DATA_BYTES + SPARE_BYTES) + 8,
    localparam int N          = DATA_BYTES + SPARE_BYTES,
    localparam int CW         = $clog2(N),
    localparam int SW         = (SECTORS > 1) ? $clog2(SECTORS) : 1,
    localparam int AW         = $clog2(SECTORS * N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stg_we,
    input  logic [CW-1:0]     stg_col,
    input  logic [7:0]        stg_wdata,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [SW-1:0]     cmd_sector,
    input  logic [CW-1:0]     cmd_col,
    input  logic [SW-1:0]     rd_sector,
    input  logic [CW-1:0]     rd_col,
    output logic [7:0]        rd_data,
    output logic              ready,
    output logic [STAT_W-1:0] status
);

    logic          accept;
    logic          stg_wr;
    logic          ran_q;
    logic          eng_fail;
    logic          eng_verr;
    logic [AW-1:0] eng_addr;
    logic          arr_we;
    logic [7:0]    arr_wdata;
    logic [CW-1:0] eng_stg_addr;
    logic [AW-1:0] host_addr;
    logic [1:0][AW-1:0] arr_raddr;
    logic [1:0][7:0]    arr_rdata;
    logic [0:0][CW-1:0] stg_raddr;
    logic [0:0][7:0]    stg_rdata;
    logic          done;

    assign accept    = ready & cmd_valid & (cmd_op <= OP_LAST);
    assign stg_wr    = stg_we & ready;
    assign host_addr = AW'(rd_sector) * AW'(N) + AW'(rd_col);
    assign arr_raddr = {eng_addr, host_addr};
    assign stg_raddr = eng_stg_addr;
    assign rd_data   = arr_rdata[0];

    // Remember that at least one operation has been accepted since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      ran_q <= 1'b0;
        else if (accept) ran_q <= 1'b1;
    end

    assign done   = ready & ran_q;
    assign status = {eng_verr & done, eng_fail & done, done};

    sps_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .ready (ready)
    );

    sps_byte_store #(.DEPTH(N), .RD_PORTS(1)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (stg_wr),
        .waddr (stg_col),
        .wdata (stg_wdata),
        .raddr (stg_raddr),
        .rdata (stg_rdata)
    );

    sps_byte_store #(.DEPTH(SECTORS * N), .RD_PORTS(2)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (eng_addr),
        .wdata (arr_wdata),
        .raddr (arr_raddr),
        .rdata (arr_rdata)
    );

    sps_engine #(.SECTORS(SECTORS), .N(N), .SPARE_COL(DATA_BYTES)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .op_in     (cmd_op),
        .sector_in (cmd_sector),
        .col_in    (cmd_col),
        .arr_rdata (arr_rdata[1]),
        .stg_rdata (stg_rdata[0]),
        .arr_addr  (eng_addr),
        .arr_we    (arr_we),
        .arr_wdata (arr_wdata),
        .stg_addr  (eng_stg_addr),
        .fail      (eng_fail),
        .verr      (eng_verr)
    );

endmodule

// File: rtl/sps_checker.sv
// Module: temporal checks for sps_sequencer, attached by bind. Measures the
// busy window with its own counter rather than a long delay.
module sps_checker #(
    parameter int BUSY_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic [2:0] status,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       arr_we
);

    int unsigned low_cnt;

    // Count consecutive cycles with ready low.
    always_ff @(posedge clk) begin
        if (!rst_n)     low_cnt <= 0;
        else if (ready) low_cnt <= 0;
        else            low_cnt <= low_cnt + 1;
    end

    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cmd_valid && cmd_op <= 3'd4) |=> !ready);

    a_r2_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (low_cnt == BUSY_CYCLES));

    a_r2_done_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> status[0]);

    a_r2_status_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (status == 3'b000));

    a_r8_ignored_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(cmd_valid && cmd_op <= 3'd4)) |=> ready);

    a_r8_ignored_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(cmd_valid && cmd_op <= 3'd4)) |=> $stable(status));

    a_r4_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !ready);

endmodule

bind sps_sequencer sps_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .status    (status),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .arr_we    (arr_we)
);

// File: tb/sps_sequencer_test.sv
// Bench: directed corner cases plus seeded random commands, checked
// against a byte-level model built from the requirements.
module sps_sequencer_test;

    localparam int SECTORS = 4;
    localparam int DB      = 32;
    localparam int SB      = 4;
    localparam int N       = DB + SB;
    localparam int BUSY    = 3 * N + 8;
    localparam int CW      = $clog2(N);
    localparam int SW      = $clog2(SECTORS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stg_we = 1'b0;
    logic [CW-1:0] stg_col = '0;
    logic [7:0]    stg_wdata = '0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [SW-1:0] cmd_sector = '0;
    logic [CW-1:0] cmd_col = '0;
    logic [SW-1:0] rd_sector = '0;
    logic [CW-1:0] rd_col = '0;
    logic [7:0]    rd_data;
    logic          ready;
    logic [2:0]    status;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mdl [SECTORS*N];
    logic [7:0] smdl [N];

    always #2.5 clk = ~clk;

    sps_sequencer uut (
        .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .stg_col(stg_col),
        .stg_wdata(stg_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sector(cmd_sector), .cmd_col(cmd_col), .rd_sector(rd_sector),
        .rd_col(rd_col), .rd_data(rd_data), .ready(ready), .status(status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare every stored byte with the model, one check per sector.
    task automatic check_all(input string req);
        for (int s = 0; s < SECTORS; s++) begin
            int bad = 0;
            int act = 0;
            int exp = 0;
            for (int c = 0; c < N; c++) begin
                @(negedge clk);
                rd_sector = SW'(s);
                rd_col    = CW'(c);
                #1;
                if (rd_data !== mdl[s*N+c] && bad == 0) begin
                    act = int'(rd_data);
                    exp = int'(mdl[s*N+c]);
                end
                if (rd_data !== mdl[s*N+c]) bad++;
            end
            chk(bad == 0, req, act, exp);
        end
    endtask

    task automatic load_stage(input int mode);
        for (int c = 0; c < N; c++) begin
            logic [7:0] v;
            case (mode)
                0: v = 8'($urandom);
                1: v = 8'(c * 7 + 3);
                2: v = 8'hA5 ^ 8'(c);
                default: v = (($urandom % 3) == 0) ? 8'hFF : 8'($urandom);
            endcase
            @(negedge clk);
            stg_we = 1'b1; stg_col = CW'(c); stg_wdata = v;
            smdl[c] = v;
        end
        @(negedge clk);
        stg_we = 1'b0;
    endtask

    // Issue one command, measure busy, check status and contents.
    task automatic run_cmd(input int op, input int sec, input int col,
                           input bit inject, input string req);
        int first;
        bit chk_ff;
        bit exp_fail;
        int low;
        first  = (op == 2) ? col : (op == 3) ? DB : 0;
        chk_ff = (op >= 2);
        exp_fail = 1'b0;
        if (chk_ff)
            for (int c = first; c < N; c++)
                if (mdl[sec*N+c] != 8'hFF) exp_fail = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_sector = SW'(sec); cmd_col = CW'(col);
        @(negedge clk);
        cmd_valid = 1'b0;
        low = 0;
        while (!ready) begin
            low++;
            if (inject && low == 5) begin
                cmd_valid = 1'b1; cmd_op = 3'd0; cmd_sector = SW'((sec + 1) % SECTORS);
                stg_we = 1'b1; stg_col = '0; stg_wdata = ~smdl[0];
            end else begin
                cmd_valid = 1'b0; stg_we = 1'b0;
            end
            if (!ready) chk(status == 3'b000, "R2 status zero while busy", int'(status), 0);
            @(negedge clk);
        end
        cmd_valid = 1'b0; stg_we = 1'b0;
        chk(low == BUSY, "R2 busy length", low, BUSY);
        chk(status[0] == 1'b1, "R2 done bit", int'(status[0]), 1);
        chk(status[1] == exp_fail, {req, " fail bit"}, int'(status[1]), int'(exp_fail));
        chk(status[2] == 1'b0, "R10 verify bit", int'(status[2]), 0);
        if (!exp_fail)
            for (int c = first; c < N; c++)
                mdl[sec*N+c] = (op == 0) ? 8'hFF : (mdl[sec*N+c] & smdl[c]);
        check_all(req);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < SECTORS*N; i++) mdl[i] = 8'hFF;
        for (int i = 0; i < N; i++) smdl[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1 ready", int'(ready), 1);
        chk(status == 3'b000, "R1 status", int'(status), 0);
        check_all("R1 erased contents");

        // R7 blank program on erased sector, then rejected on second try
        load_stage(1);
        run_cmd(4, 0, 0, 1'b0, "R7 blank program");
        load_stage(2);
        run_cmd(4, 0, 0, 1'b0, "R7 non-blank rejected");
        // R4 plain program ANDs into existing data
        run_cmd(1, 0, 0, 1'b0, "R4 plain AND program");
        // R3 erase
        run_cmd(0, 0, 0, 1'b0, "R3 erase");
        // R5 column program, then overlapping column rejected
        load_stage(1);
        run_cmd(2, 1, 10, 1'b0, "R5 column program");
        run_cmd(2, 1, 5, 1'b0, "R5 overlap rejected");
        run_cmd(2, 1, N - 1, 1'b0, "R5 last column");
        // R6 spare program then second spare rejected
        run_cmd(3, 2, 0, 1'b0, "R6 spare program");
        run_cmd(3, 2, 0, 1'b0, "R6 spare rejected");
        // R8 start column past the end changes nothing
        run_cmd(2, 3, N + 2, 1'b0, "R8 empty column range");
        // R8 illegal opcode ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_sector = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(ready == 1'b1, "R8 illegal op keeps ready", int'(ready), 1);
        chk(status == 3'b001, "R8 illegal op keeps status", int'(status), 1);
        // R8 and R9: command and staging write during busy are ignored
        run_cmd(0, 3, 0, 1'b0, "R3 erase before busy test");
        load_stage(2);
        run_cmd(4, 3, 0, 1'b1, "R9 staging write while busy ignored, R8 busy command ignored");

        // Random mix
        for (int k = 0; k < 40; k++) begin
            int op  = int'($urandom % 5);
            int sec = int'($urandom % SECTORS);
            int col = int'($urandom % (N + 4));
            if (($urandom % 4) == 0) run_cmd(0, sec, 0, 1'b0, "R3 random erase");
            load_stage(($urandom % 2 == 0) ? 0 : 3);
            case (op)
                0: run_cmd(0, sec, 0, 1'b0, "R3 random");
                1: run_cmd(1, sec, 0, 1'b0, "R4 random");
                2: run_cmd(2, sec, col, 1'b0, "R5 random");
                3: run_cmd(3, sec, 0, 1'b0, "R6 random");
                default: run_cmd(4, sec, 0, 1'b0, "R7 random");
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule